// File: doc/BRIEF.md
# Two-Antenna Space-Time Pair Combiner

This block sits after the FFT and channel estimator of a receiver with two antennas that listens to a two-transmitter space-time block code. The code spreads each pair of data symbols over two consecutive OFDM symbols on the same subcarrier. The block stores the first symbol of each pair, one value per subcarrier and per antenna. While the second symbol streams in, it combines the stored value with the new one, subcarrier by subcarrier. The two received values are weighted with the channel pair of each antenna, which is valid for both symbols of the pair.

For each subcarrier the block returns two complex numerators and the total channel power, which is their common denominator. The division is left to the consumer, so the block itself does not divide. The subcarrier index travels with each result. A zero channel power produces zero outputs and an invalid flag. Both antenna branches are treated as having the same gain, so no per-antenna correction is applied.

Top module: `alamouti_combiner`

## Requirements
- R1: After reset, `out_valid` and `out_invalid` are low and every data output is zero.
- R2: An input with `in_valid`=1 and `in_second`=0 stores both antennas' samples at index `in_sc` and produces no output in the following cycle.
- R3: An input with `in_valid`=1 and `in_second`=1 produces `out_valid`=1 one clock edge later, with `out_sc` equal to that input's `in_sc`. No other input raises `out_valid`.
- R4: The first numerator is the sum over antennas i of conj(Ha_i)·S1_i + Hb_i·conj(S2_i). S1 is the stored sample, S2 is the sample arriving now, Ha is the `ha_*` channel and Hb is the `hb_*` channel.
- R5: The second numerator is the sum over antennas of conj(Hb_i)·S1_i − Ha_i·conj(S2_i).
- R6: `out_power` is the exact unsigned sum over antennas of |Ha_i|²+|Hb_i|², computed from the channel values presented with the second symbol.
- R7: Each numerator is summed at full precision over both antennas and only then rounded. Rounding drops the low W+1 bits by adding 2^W and shifting right arithmetically. The result is W+2 bits wide (10 bits at W=8, divisor 512).
- R8: Inputs of the second symbol never change the stored samples. Repeated second-symbol passes over the same subcarrier all combine with the same stored first symbol.
- R9: When the channel power is zero, all four estimate outputs are zero and `out_invalid`=1. Otherwise `out_invalid`=0.
- R10: Channel inputs presented together with first-symbol samples have no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample set is present |
| in_second | input | 1 | 0: first symbol of pair, 1: second |
| in_sc | input | SCW | Subcarrier index |
| rx_re | input | 2×W | Real part of received sample, per antenna |
| rx_im | input | 2×W | Imaginary part of received sample, per antenna |
| ha_re | input | 2×W | Real part of first-transmitter channel, per antenna |
| ha_im | input | 2×W | Imaginary part of first-transmitter channel, per antenna |
| hb_re | input | 2×W | Real part of second-transmitter channel, per antenna |
| hb_im | input | 2×W | Imaginary part of second-transmitter channel, per antenna |
| out_valid | output | 1 | Result present |
| out_sc | output | SCW | Subcarrier index of the result |
| est1_re | output | W+2 | First numerator, real |
| est1_im | output | W+2 | First numerator, imaginary |
| est2_re | output | W+2 | Second numerator, real |
| est2_im | output | W+2 | Second numerator, imaginary |
| out_power | output | 2W+3 | Channel power (common denominator) |
| out_invalid | output | 1 | Channel power was zero |

## Verification
The hardest situation to reach is a second-symbol pass that reuses a buffer line written long before. A design that lets second-symbol traffic overwrite the buffer, or that reads the wrong line, behaves correctly when each pair is sent once in order. The stimulus therefore sends a second symbol twice over the same stored symbol with new data, and also visits subcarriers in reverse order. First-symbol writes carry random channel values that must leave no trace. Full-scale negative samples and channels drive the rounding and the power sum to their extremes.

// File: rtl/alamouti_pkg.sv
package alamouti_pkg;
    localparam int NRX = 2;
endpackage

// File: rtl/alamouti_cmul.sv
module alamouti_cmul #(
    parameter int W      = 8,
    parameter bit CONJ_A = 1'b0,
    parameter bit CONJ_B = 1'b0
) (
    input  logic signed [W-1:0]       a_re,
    input  logic signed [W-1:0]       a_im,
    input  logic signed [W-1:0]       b_re,
    input  logic signed [W-1:0]       b_im,
    output logic signed [2*W+1:0]     p_re,
    output logic signed [2*W+1:0]     p_im
);
    localparam int EW = W + 1;
    localparam int PW = 2 * EW;

    logic signed [EW-1:0] ar, ai, br, bi;
    logic signed [PW-1:0] rr, ii, ri, ir;

    assign ar = {a_re[W-1], a_re};
    assign br = {b_re[W-1], b_re};

    generate
        if (CONJ_A) begin : g_conj_a
            assign ai = -{a_im[W-1], a_im};
        end else begin : g_plain_a
            assign ai = {a_im[W-1], a_im};
        end
        if (CONJ_B) begin : g_conj_b
            assign bi = -{b_im[W-1], b_im};
        end else begin : g_plain_b
            assign bi = {b_im[W-1], b_im};
        end
    endgenerate

    always_comb begin
        rr   = PW'(ar) * PW'(br);
        ii   = PW'(ai) * PW'(bi);
        ri   = PW'(ar) * PW'(bi);
        ir   = PW'(ai) * PW'(br);
        p_re = rr - ii;
        p_im = ri + ir;
    end
endmodule

// File: rtl/alamouti_pair_buf.sv
module alamouti_pair_buf #(
    parameter int W   = 8,
    parameter int NSC = 16,
    parameter int SCW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SCW-1:0]      addr,
    input  logic signed [W-1:0] wr_re,
    input  logic signed [W-1:0] wr_im,
    output logic signed [W-1:0] rd_re,
    output logic signed [W-1:0] rd_im
);
    logic [NSC-1:0][2*W-1:0] mem_d, mem_q;
    logic                    in_range;

    assign in_range = (int'(addr) < NSC);

    always_comb begin
        mem_d = mem_q;
        if (wr_en && in_range) begin
            mem_d[addr] = {wr_re, wr_im};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        if (in_range) begin
            rd_re = mem_q[addr][2*W-1:W];
            rd_im = mem_q[addr][W-1:0];
        end else begin
            rd_re = '0;
            rd_im = '0;
        end
    end

    // R8: the stored first symbol is untouched by any cycle that does not write
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem_q));
endmodule

// File: rtl/alamouti_combiner.sv
module alamouti_combiner
    import alamouti_pkg::*;
#(
    parameter int W   = 8,
    parameter int NSC = 16,
    parameter int SCW = (NSC > 1) ? $clog2(NSC) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_second,
    input  logic [SCW-1:0]                in_sc,
    input  logic [NRX-1:0][W-1:0]         rx_re,
    input  logic [NRX-1:0][W-1:0]         rx_im,
    input  logic [NRX-1:0][W-1:0]         ha_re,
    input  logic [NRX-1:0][W-1:0]         ha_im,
    input  logic [NRX-1:0][W-1:0]         hb_re,
    input  logic [NRX-1:0][W-1:0]         hb_im,
    output logic                          out_valid,
    output logic [SCW-1:0]                out_sc,
    output logic signed [W+1:0]           est1_re,
    output logic signed [W+1:0]           est1_im,
    output logic signed [W+1:0]           est2_re,
    output logic signed [W+1:0]           est2_im,
    output logic [2*W+2:0]                out_power,
    output logic                          out_invalid
);
    localparam int PW   = 2 * W + 2;
    localparam int P    = 2 * W + 3;
    localparam int OW   = W + 2;
    localparam int SH   = W + 1;
    localparam logic signed [P-1:0] HALF = P'(1) <<< (SH - 1);
    localparam logic [P-1:0] MAXP = P'(NRX) * P'(4) * (P'(1) << (2 * W - 2));

    typedef struct packed {
        logic                 valid;
        logic [SCW-1:0]       sc;
        logic signed [OW-1:0] e1r;
        logic signed [OW-1:0] e1i;
        logic signed [OW-1:0] e2r;
        logic signed [OW-1:0] e2i;
        logic [P-1:0]         pow;
        logic                 inv;
    } out_t;

    out_t out_d, out_q;

    logic                 wr_en;
    logic signed [W-1:0]  s1_re [NRX];
    logic signed [W-1:0]  s1_im [NRX];
    logic signed [PW-1:0] x1a_re [NRX], x1a_im [NRX];
    logic signed [PW-1:0] x1b_re [NRX], x1b_im [NRX];
    logic signed [PW-1:0] x2a_re [NRX], x2a_im [NRX];
    logic signed [PW-1:0] x2b_re [NRX], x2b_im [NRX];

    assign wr_en = in_valid && !in_second;

    generate
        for (genvar i = 0; i < NRX; i++) begin : g_ant
            alamouti_pair_buf #(.W(W), .NSC(NSC), .SCW(SCW)) u_buf (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (wr_en),
                .addr  (in_sc),
                .wr_re (rx_re[i]),
                .wr_im (rx_im[i]),
                .rd_re (s1_re[i]),
                .rd_im (s1_im[i])
            );
            // conj(Ha) * S1
            alamouti_cmul #(.W(W), .CONJ_A(1'b1), .CONJ_B(1'b0)) u_x1a (
                .a_re(ha_re[i]), .a_im(ha_im[i]), .b_re(s1_re[i]), .b_im(s1_im[i]),
                .p_re(x1a_re[i]), .p_im(x1a_im[i]));
            // Hb * conj(S2)
            alamouti_cmul #(.W(W), .CONJ_A(1'b0), .CONJ_B(1'b1)) u_x1b (
                .a_re(hb_re[i]), .a_im(hb_im[i]), .b_re(rx_re[i]), .b_im(rx_im[i]),
                .p_re(x1b_re[i]), .p_im(x1b_im[i]));
            // conj(Hb) * S1
            alamouti_cmul #(.W(W), .CONJ_A(1'b1), .CONJ_B(1'b0)) u_x2a (
                .a_re(hb_re[i]), .a_im(hb_im[i]), .b_re(s1_re[i]), .b_im(s1_im[i]),
                .p_re(x2a_re[i]), .p_im(x2a_im[i]));
            // Ha * conj(S2)
            alamouti_cmul #(.W(W), .CONJ_A(1'b0), .CONJ_B(1'b1)) u_x2b (
                .a_re(ha_re[i]), .a_im(ha_im[i]), .b_re(rx_re[i]), .b_im(rx_im[i]),
                .p_re(x2b_re[i]), .p_im(x2b_im[i]));
        end
    endgenerate

    function automatic logic signed [OW-1:0] round_out(input logic signed [P-1:0] v);
        logic signed [P-1:0] t;
        t = (v + HALF) >>> SH;
        return t[OW-1:0];
    endfunction

    logic signed [P-1:0] acc1_re, acc1_im, acc2_re, acc2_im, acc_pow;
    logic signed [P-1:0] tar, tai, tbr, tbi;

    always_comb begin
        acc1_re = '0;
        acc1_im = '0;
        acc2_re = '0;
        acc2_im = '0;
        acc_pow = '0;
        for (int i = 0; i < NRX; i++) begin
            acc1_re = acc1_re + P'(x1a_re[i]) + P'(x1b_re[i]);
            acc1_im = acc1_im + P'(x1a_im[i]) + P'(x1b_im[i]);
            acc2_re = acc2_re + P'(x2a_re[i]) - P'(x2b_re[i]);
            acc2_im = acc2_im + P'(x2a_im[i]) - P'(x2b_im[i]);
            tar = P'($signed(ha_re[i]));
            tai = P'($signed(ha_im[i]));
            tbr = P'($signed(hb_re[i]));
            tbi = P'($signed(hb_im[i]));
            acc_pow = acc_pow + tar * tar + tai * tai + tbr * tbr + tbi * tbi;
        end
    end

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid && in_second;
        out_d.inv   = 1'b0;
        if (in_valid && in_second) begin
            out_d.sc  = in_sc;
            out_d.pow = acc_pow;
            if (acc_pow == '0) begin
                out_d.e1r = '0;
                out_d.e1i = '0;
                out_d.e2r = '0;
                out_d.e2i = '0;
                out_d.inv = 1'b1;
            end else begin
                out_d.e1r = round_out(acc1_re);
                out_d.e1i = round_out(acc1_im);
                out_d.e2r = round_out(acc2_re);
                out_d.e2i = round_out(acc2_im);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid   = out_q.valid;
    assign out_sc      = out_q.sc;
    assign est1_re     = out_q.e1r;
    assign est1_im     = out_q.e1i;
    assign est2_re     = out_q.e2r;
    assign est2_im     = out_q.e2i;
    assign out_power   = out_q.pow;
    assign out_invalid = out_q.inv;

    // R2: a first-symbol write never yields a result
    p_first_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_second) |=> !out_valid);

    // R3: a second-symbol input yields a result carrying its index
    p_sc_carried_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_second) |=> (out_valid && out_sc == $past(in_sc)));

    // R9: invalid results are all-zero and come with zero power
    p_invalid_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (out_valid && out_power == '0 && est1_re == '0 &&
                         est1_im == '0 && est2_re == '0 && est2_im == '0));

    // R6: channel power never exceeds the full-scale bound
    p_power_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_power <= MAXP));
endmodule

// File: tb/alamouti_combiner_tb.sv
module alamouti_combiner_tb;
    localparam int W   = 8;
    localparam int NSC = 16;
    localparam int SCW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_second = 1'b0;
    logic [SCW-1:0] in_sc = '0;
    logic [1:0][W-1:0] rx_re = '0, rx_im = '0, ha_re = '0, ha_im = '0, hb_re = '0, hb_im = '0;
    logic out_valid;
    logic [SCW-1:0] out_sc;
    logic signed [W+1:0] est1_re, est1_im, est2_re, est2_im;
    logic [2*W+2:0] out_power;
    logic out_invalid;

    always #10 clk = ~clk;

    alamouti_combiner #(.W(W), .NSC(NSC), .SCW(SCW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_second(in_second),
        .in_sc(in_sc), .rx_re(rx_re), .rx_im(rx_im), .ha_re(ha_re), .ha_im(ha_im),
        .hb_re(hb_re), .hb_im(hb_im), .out_valid(out_valid), .out_sc(out_sc),
        .est1_re(est1_re), .est1_im(est1_im), .est2_re(est2_re), .est2_im(est2_im),
        .out_power(out_power), .out_invalid(out_invalid));

    typedef struct {
        int     sc;
        longint e1r, e1i, e2r, e2i, pw;
        bit     inv;
    } exp_t;

    exp_t q[$];
    int n_checks = 0;
    int n_fail = 0;
    int s1r [2][NSC];
    int s1i [2][NSC];

    function automatic int rnd8();
        logic [7:0] v;
        v = 8'($urandom);
        return int'($signed(v));
    endfunction

    function automatic longint rnd_out(longint v);
        return (v + 256) >>> 9;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // first symbol: sample stored, junk channel presented (R10)
    task automatic drv_first(int sc, int r0, int i0, int r1, int i1);
        @(negedge clk);
        in_valid = 1'b1; in_second = 1'b0; in_sc = SCW'(sc);
        rx_re[0] = 8'(r0); rx_im[0] = 8'(i0); rx_re[1] = 8'(r1); rx_im[1] = 8'(i1);
        for (int a = 0; a < 2; a++) begin
            ha_re[a] = 8'($urandom); ha_im[a] = 8'($urandom);
            hb_re[a] = 8'($urandom); hb_im[a] = 8'($urandom);
        end
        s1r[0][sc] = r0; s1i[0][sc] = i0; s1r[1][sc] = r1; s1i[1][sc] = i1;
    endtask

    task automatic drv_second(int sc, int s2r[2], int s2i[2], int ar[2], int ai[2], int br[2], int bi[2]);
        exp_t e;
        longint x1r, x1i, x2r, x2i, pw;
        @(negedge clk);
        in_valid = 1'b1; in_second = 1'b1; in_sc = SCW'(sc);
        x1r = 0; x1i = 0; x2r = 0; x2i = 0; pw = 0;
        for (int a = 0; a < 2; a++) begin
            rx_re[a] = 8'(s2r[a]); rx_im[a] = 8'(s2i[a]);
            ha_re[a] = 8'(ar[a]); ha_im[a] = 8'(ai[a]);
            hb_re[a] = 8'(br[a]); hb_im[a] = 8'(bi[a]);
            // R4: conj(Ha)S1 + Hb conj(S2)
            x1r += ar[a]*s1r[a][sc] + ai[a]*s1i[a][sc] + br[a]*s2r[a] + bi[a]*s2i[a];
            x1i += ar[a]*s1i[a][sc] - ai[a]*s1r[a][sc] + bi[a]*s2r[a] - br[a]*s2i[a];
            // R5: conj(Hb)S1 - Ha conj(S2)
            x2r += br[a]*s1r[a][sc] + bi[a]*s1i[a][sc] - (ar[a]*s2r[a] + ai[a]*s2i[a]);
            x2i += br[a]*s1i[a][sc] - bi[a]*s1r[a][sc] - (ai[a]*s2r[a] - ar[a]*s2i[a]);
            pw  += ar[a]*ar[a] + ai[a]*ai[a] + br[a]*br[a] + bi[a]*bi[a];
        end
        e.sc = sc; e.pw = pw;
        if (pw == 0) begin
            e.e1r = 0; e.e1i = 0; e.e2r = 0; e.e2i = 0; e.inv = 1'b1;
        end else begin
            // R7: round after full-precision sum
            e.e1r = rnd_out(x1r); e.e1i = rnd_out(x1i);
            e.e2r = rnd_out(x2r); e.e2i = rnd_out(x2i); e.inv = 1'b0;
        end
        q.push_back(e);
    endtask

    task automatic drv_second_rand(int sc);
        int a2r[2], a2i[2], har[2], hai[2], hbr[2], hbi[2];
        for (int a = 0; a < 2; a++) begin
            a2r[a] = rnd8(); a2i[a] = rnd8();
            har[a] = rnd8(); hai[a] = rnd8(); hbr[a] = rnd8(); hbi[a] = rnd8();
        end
        drv_second(sc, a2r, a2i, har, hai, hbr, hbi);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                chk("R2/R3", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R3", "out_sc", longint'(out_sc), e.sc);
                chk("R4", "est1_re", longint'(est1_re), e.e1r);
                chk("R4", "est1_im", longint'(est1_im), e.e1i);
                chk("R5", "est2_re", longint'(est2_re), e.e2r);
                chk("R5", "est2_im", longint'(est2_im), e.e2i);
                chk("R6", "out_power", longint'(out_power), e.pw);
                chk("R9", "out_invalid", longint'(out_invalid), longint'(e.inv));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int zr[2], zi[2], mr[2], mi[2], pr[2];
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid", longint'(out_valid), 0);
        chk("R1", "out_invalid", longint'(out_invalid), 0);
        chk("R1", "est1_re", longint'(est1_re), 0);
        chk("R1", "out_power", longint'(out_power), 0);
        rst_n = 1'b1;

        // pass A: random pair, in order (R2, R4-R7, R10)
        for (int s = 0; s < NSC; s++) drv_first(s, rnd8(), rnd8(), rnd8(), rnd8());
        idle();
        idle();
        for (int s = 0; s < NSC; s++) drv_second_rand(s);
        idle();

        // pass B: second symbol again, reverse order, same stored first (R8, R3)
        for (int s = NSC - 1; s >= 0; s--) begin
            drv_second_rand(s);
            if (s % 3 == 0) idle();
        end
        idle();

        // extremes: full-scale negative everywhere (R7, R6)
        for (int s = 0; s < 4; s++) drv_first(s, -128, -128, -128, -128);
        mr = '{-128, -128}; mi = '{-128, -128}; pr = '{127, -128};
        drv_second(0, mr, mi, mr, mi, mr, mi);
        drv_second(1, mr, mi, pr, mi, mr, pr);
        mi = '{127, 127};
        drv_second(2, mr, mi, mi, mr, pr, mr);

        // zero channel with nonzero data (R9)
        zr = '{0, 0}; zi = '{0, 0};
        drv_second(3, pr, pr, zr, zi, zr, zi);
        // zero channel on one antenna only is still valid
        drv_second(3, pr, pr, zr, zi, '{0, 1}, zi);
        idle();
        repeat (4) idle();

        chk("R3", "pending results", q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule